// File: doc/BRIEF.md
# Control-Flow Signature Watchdog

This block sits beside a host processor and watches its instruction fetch stream. The program it watches is cut into basic blocks, and each block has exactly one entry and one exit. While a block runs, every fetched instruction word is compacted into a running 16-bit cyclic signature. The last fetch of a block is an exit marker, and that marker carries the signature the block should have produced. The monitor compares the two values, flags any difference and starts over for the next block. It also flags a block that runs on too long without reaching an exit marker. The limit for that is a programmable number of fetches.

The fetch stream enters through a valid/ready pair. The monitor is a pure observer, so it never applies back-pressure: `fetch_ready` stays high whenever the block is out of reset. A fetch is taken in every cycle in which `fetch_valid` is high. `fetch_end` and `fetch_ref` qualify that fetch and have no meaning when `fetch_valid` is low. The monitor assumes a single program thread. It does not track interleaved processes, and any corruption on the fetch link itself lowers detection coverage.

Top module: `cfsig_monitor`

## Requirements
- R1: After reset, `err_pulse` and `err_sticky` are 0, `err_count` is 0 and `fetch_ready` is 1.
- R2: The signature register is seeded with 16'hFFFF at the start of each block. Each accepted fetch with `fetch_end`=0 folds its 32-bit word into the signature within that cycle, most significant bit first, using polynomial x^16+x^12+x^5+1 (0x1021, no reflection, no final XOR).
- R3: An accepted fetch with `fetch_end`=1 compares `fetch_ref` with the signature of the words before it; the marker word itself is not folded in. The signature is then reseeded for the next block.
- R4: A failing block raises `err_pulse` in the cycle after the failing fetch. Without a new failure, the pulse drops one cycle later.
- R5: `err_sticky` sets on any failure and stays set until reset.
- R6: `err_count` adds one per failure and saturates at 255.
- R7: An accepted non-end fetch that arrives when `max_len` words have already been folded in the current block is an overrun failure. That word is discarded and a fresh block starts.
- R8: An end marker that arrives after exactly `max_len` folded words is legal and does not cause an overrun.
- R9: `fetch_ready` never drops. When `fetch_valid` is 0, `fetch_word`, `fetch_end` and `fetch_ref` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is presented |
| fetch_ready | output | 1 | Monitor accepts fetches (always 1 out of reset) |
| fetch_word | input | 32 | Fetched instruction word |
| fetch_end | input | 1 | This fetch is the block-exit marker |
| fetch_ref | input | 16 | Reference signature carried by the exit marker |
| max_len | input | 8 | Longest allowed block in folded words |
| err_pulse | output | 1 | One-cycle failure indication |
| err_sticky | output | 1 | Failure seen since reset |
| err_count | output | 8 | Saturating count of failing blocks |

## Verification
Two checks meet in one cycle when an exit marker lands on the fetch slot that the length limit guards. The signature compare has to run there, and the overrun check must stay quiet. The bench provokes this by sweeping block lengths up to and past `max_len`, with correct and corrupted references. It then reads `err_pulse` and `err_count` one cycle later against a counter model. A marker at exactly the limit must produce no failure, while one more word must produce exactly one failure, and a correctly signed block must follow it cleanly.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;
  localparam int WORD_W = 32;
  localparam int SIG_W  = 16;
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;
  localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;
endpackage

// File: rtl/cfsig_fold.sv
module cfsig_fold
  import cfsig_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int SW = SIG_W,
  parameter logic [SW-1:0] POLY = SIG_POLY
) (
  input  logic [SW-1:0] sig_in,
  input  logic [DW-1:0] data,
  output logic [SW-1:0] sig_out
);
  logic [SW-1:0] stage [DW+1];
  assign stage[0] = sig_in;
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][SW-1] ^ data[DW-1-i];
    assign stage[i+1] = {stage[i][SW-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
  assign sig_out = stage[DW];
endmodule

// File: rtl/cfsig_len_guard.sv
module cfsig_len_guard #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fold_req,
  input  logic             blk_close,
  input  logic [LEN_W-1:0] max_len,
  output logic             overrun
);
  logic [LEN_W-1:0] cnt_q;

  assign overrun = fold_req && (cnt_q >= max_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (blk_close || overrun) cnt_q <= '0;
    else if (fold_req)             cnt_q <= cnt_q + 1'b1;
  end

  p_len_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_req && !overrun && !blk_close) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_len_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_close || overrun) |=> cnt_q == '0);
endmodule

// File: rtl/cfsig_err_track.sv
module cfsig_err_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail,
  output logic             pulse,
  output logic             sticky,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      sticky <= 1'b0;
      count  <= '0;
    end else begin
      pulse <= fail;
      if (fail) sticky <= 1'b1;
      if (fail && count != CNT_MAX) count <= count + 1'b1;
    end
  end

  p_sticky_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sticky |=> sticky);
  p_pulse_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> sticky);
  p_count_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX) |=> (count == CNT_MAX));
  p_count_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fail |=> $stable(count));
endmodule

// File: rtl/cfsig_monitor.sv
module cfsig_monitor
  import cfsig_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              fetch_end,
  input  logic [SIG_W-1:0]  fetch_ref,
  input  logic [LEN_W-1:0]  max_len,
  output logic              err_pulse,
  output logic              err_sticky,
  output logic [CNT_W-1:0]  err_count
);
  logic              fold_req, blk_close, overrun, mismatch;
  logic [SIG_W-1:0]  sig_q, sig_next;
  logic              rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign fetch_ready = rdy_q || rst_n;

  assign fold_req  = fetch_valid && !fetch_end;
  assign blk_close = fetch_valid && fetch_end;
  assign mismatch  = blk_close && (fetch_ref != sig_q);

  cfsig_fold #(.DW(WORD_W), .SW(SIG_W), .POLY(SIG_POLY)) u_fold (
    .sig_in (sig_q),
    .data   (fetch_word),
    .sig_out(sig_next)
  );

  cfsig_len_guard #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .fold_req (fold_req),
    .blk_close(blk_close),
    .max_len  (max_len),
    .overrun  (overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sig_q <= SIG_SEED;
    else if (blk_close || overrun) sig_q <= SIG_SEED;
    else if (fold_req)             sig_q <= sig_next;
  end

  cfsig_err_track #(.CNT_W(CNT_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .fail  (mismatch || overrun),
    .pulse (err_pulse),
    .sticky(err_sticky),
    .count (err_count)
  );

  p_idle_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !err_pulse);
  p_match_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_close && fetch_ref == sig_q) |=> !err_pulse);
  p_close_reseed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_close |=> sig_q == SIG_SEED);
  p_ready_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready);
endmodule

// File: tb/cfsig_monitor_tb.sv
`timescale 1ns/1ps
module cfsig_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_word = '0;
  logic        fetch_end = 1'b0;
  logic [15:0] fetch_ref = '0;
  logic [7:0]  max_len = 8'd8;
  logic        err_pulse, err_sticky;
  logic [7:0]  err_count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  logic [31:0] seedw = 32'h1234_5678;

  always #4 clk = ~clk;

  cfsig_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_word(fetch_word), .fetch_end(fetch_end), .fetch_ref(fetch_ref),
    .max_len(max_len), .err_pulse(err_pulse), .err_sticky(err_sticky),
    .err_count(err_count)
  );

  function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic top = r[15] ^ w[i];
      r = r << 1;
      if (top) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [31:0] next_word(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [31:0] w, input logic e, input logic [15:0] r);
    fetch_valid = v; fetch_word = w; fetch_end = e; fetch_ref = r;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, 32'hDEAD_BEEF, 1'b1, 16'h0BAD);
  endtask

  task automatic note_fail();
    if (exp_cnt < 255) exp_cnt++;
  endtask

  // Run a block of n words, closing with correct or corrupted reference.
  task automatic run_block(input int n, input bit bad, input string req);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      seedw = next_word(seedw);
      s = crc_word(s, seedw);
      cyc(1'b1, seedw, 1'b0, 16'h0);
    end
    cyc(1'b1, 32'hFFFF_FFFF, 1'b1, bad ? (s ^ 16'h0040) : s);
    if (bad) note_fail();
    chk(req, err_pulse, bad);
    chk("R6", err_count, exp_cnt[7:0]);
    idle();
    chk("R4", err_pulse, 1'b0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", err_pulse, 0); chk("R1", err_sticky, 0); chk("R1", err_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", fetch_ready, 1);

    // Known vector: one word 0x00000000 from seed FFFF
    cyc(1'b1, 32'h0, 1'b0, 16'h0);
    cyc(1'b1, 32'h0, 1'b1, crc_word(16'hFFFF, 32'h0));
    chk("R2", err_pulse, 0);
    idle();

    // Sweep block lengths, good then bad
    for (int n = 0; n <= 8; n++) begin
      run_block(n, 1'b0, "R3");
      chk("R5", err_sticky, exp_cnt != 0);
      run_block(n, 1'b1, "R4");
      chk("R5", err_sticky, 1);
    end

    // Ignored end/ref while valid low, mid-block
    begin
      logic [15:0] s;
      seedw = next_word(seedw);
      s = crc_word(16'hFFFF, seedw);
      cyc(1'b1, seedw, 1'b0, 16'h0);
      cyc(1'b0, 32'h5555_AAAA, 1'b1, 16'h1357);
      chk("R9", err_pulse, 0);
      chk("R9", fetch_ready, 1);
      cyc(1'b1, 32'h1, 1'b1, s);
      chk("R9", err_pulse, 0);
      chk("R9", err_count, exp_cnt[7:0]);
      idle();
    end

    // Length limit boundary: max_len 3
    max_len = 8'd3;
    run_block(3, 1'b0, "R8");
    run_block(3, 1'b1, "R8");
    begin
      for (int k = 0; k < 3; k++) cyc(1'b1, 32'hA0 + k, 1'b0, 16'h0);
      chk("R7", err_pulse, 0);
      cyc(1'b1, 32'hBEEF, 1'b0, 16'h0);
      note_fail();
      chk("R7", err_pulse, 1);
      chk("R7", err_count, exp_cnt[7:0]);
      idle();
    end
    run_block(2, 1'b0, "R7");
    max_len = 8'd0;
    cyc(1'b1, 32'h77, 1'b0, 16'h0);
    note_fail();
    chk("R7", err_pulse, 1);
    run_block(0, 1'b0, "R8");
    max_len = 8'd8;

    // Saturation
    for (int k = 0; k < 260; k++) begin
      cyc(1'b1, 32'h0, 1'b1, 16'h0000);
      note_fail();
    end
    chk("R6", err_count, 8'd255);
    chk("R4", err_pulse, 1);
    idle();
    run_block(1, 1'b1, "R6");
    chk("R6", err_count, 8'd255);

    // Reset clears sticky
    rst_n = 1'b0;
    @(negedge clk);
    chk("R5", err_sticky, 0);
    chk("R1", err_count, 0);
    rst_n = 1'b1;
    exp_cnt = 0;
    @(negedge clk);
    run_block(4, 1'b0, "R3");
    finish_run();
  end
endmodule